// File: doc/BRIEF.md
# Feedback-Wired SDRAM Address Preload Sequencer

This sequencer places a chosen 16-bit value on the address inputs of an SDRAM whose data pins for two byte lanes are wired straight back to those same address inputs. No external latch holds the address. Instead the sequencer stores the two address bytes in the first columns of row 0 during a burst write that it keeps paused with the clock enable. It then starts a burst read and steps it with the clock enable until the stored bytes come out on the fed-back data pins, where they become the address.

The address drivers stay released for the whole sequence, so pull-down resistors select row 0 and start every burst at column 0. A host gives a one-cycle start pulse together with the target address and a bank value. It waits for the one-cycle done pulse, after which the fed-back address is present. All outputs are registered, and the sequence has a fixed length of 19 cycles.

Top module: `fbaddr_preload`

## Requirements
- R1: After reset and while idle, the outputs show a NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), cke_o high, every dqm_o bit high (1 = lane masked), bus_oe_o low, bus_o zero, done_o low and addr_oe_o high.
- R2: The register edge that samples start_i makes the outputs show ACTIVATE (0,0,1,1) with all lanes masked and addr_oe_o low. addr_oe_o stays low until done_o has been shown.
- R3: On the next cycle the outputs show WRITE (0,1,0,0) with cke_o high and all lanes masked. On the cycle after that cke_o is low, pausing the burst. Any command other than NOP is shown only with cke_o high.
- R4: Two cycles follow with only lane LO_LANE (default 0) unmasked, bus_o equal to target bits 7:0 and bus_oe_o high. cke_o is low on the first of them and high on the second.
- R5: Next comes a cycle with cke_o low and all lanes masked. Then two cycles with only lane HI_LANE (default 1) unmasked, bus_o equal to target bits 15:8 and bus_oe_o high, cke_o low then high. Then a cycle with cke_o low and all lanes masked.
- R6: Next the outputs show READ (0,1,0,1) with cke_o high and all lanes masked. Then one cycle with cke_o low and all masked. Then, with lanes LO_LANE and HI_LANE both unmasked, cke_o reads low, then high,low three times.
- R7: done_o is high for exactly one cycle, 18 cycles after the ACTIVATE cycle, with cke_o low and both address lanes unmasked. On the following cycle the block is back in the idle state of R1.
- R8: A start_i pulse while a sequence is running is ignored: the running sequence continues unchanged, with the bytes of the original target.
- R9: bank_o takes bank_i on the edge that samples start_i and holds that value until the next accepted start.
- R10: bus_oe_o is high only in the four byte-drive cycles of R4 and R5, and bus_o is zero whenever bus_oe_o is low. Each cke_o high pulse inside a sequence lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a preload |
| target_i | input | 16 | Address to place on the fed-back pins |
| bank_i | input | BANK_W | Bank value captured at start |
| cs_n_o | output | 1 | SDRAM chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | SDRAM clock enable |
| dqm_o | output | LANES | Per-lane data mask, 1 = masked |
| bank_o | output | BANK_W | Bank address, held from a register |
| bus_o | output | 8 | Shared byte bus write data |
| bus_oe_o | output | 1 | Output enable of the shared byte bus |
| addr_oe_o | output | 1 | Address-pin driver enable (low = released to pull-downs) |
| done_o | output | 1 | One-cycle pulse: fed-back address is present |

## Verification
A wrong state is visible at the ports on the next cycle, because each state has its own combination of command, clock enable, mask and bus values and all of them are registered. A skipped or repeated step moves every later row of the sequence. The wrong row then shows up within one cycle as a shifted strobe, a lane opened too early, or done arriving early or late. A strobe counter that is off by one changes the count of cke_o pulses and moves done_o by two cycles. A lost capture of the target shows up as a wrong byte in the first drive cycle.

// File: rtl/fbaddr_preload_pkg.sv
package fbaddr_preload_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ACT, ST_WR, ST_WPAUSE, ST_LO_SET, ST_LO_STB,
    ST_HI_MASK, ST_HI_SET, ST_HI_STB, ST_HI_END,
    ST_RD, ST_RPAUSE, ST_RD_OPEN, ST_R_STB, ST_R_GAP, ST_DONE
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_ACT   = 4'b0011;
  localparam logic [3:0] CMD_WRITE = 4'b0100;
  localparam logic [3:0] CMD_READ  = 4'b0101;

endpackage

// File: rtl/fbaddr_seq_fsm.sv
module fbaddr_seq_fsm
  import fbaddr_preload_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 2,
  parameter int N_STROBE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [BANK_W-1:0] bank_i,
  output seq_state_t        state_n,
  output logic [ADDR_W-1:0] tgt_n,
  output logic [BANK_W-1:0] bank_n
);
  localparam int CNT_W = $clog2(N_STROBE + 1);

  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] tgt_q;
  logic [BANK_W-1:0] bank_q;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    tgt_n   = tgt_q;
    bank_n  = bank_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_n = ST_ACT;
        tgt_n   = target_i;
        bank_n  = bank_i;
      end
      ST_ACT:     state_n = ST_WR;
      ST_WR:      state_n = ST_WPAUSE;
      ST_WPAUSE:  state_n = ST_LO_SET;
      ST_LO_SET:  state_n = ST_LO_STB;
      ST_LO_STB:  state_n = ST_HI_MASK;
      ST_HI_MASK: state_n = ST_HI_SET;
      ST_HI_SET:  state_n = ST_HI_STB;
      ST_HI_STB:  state_n = ST_HI_END;
      ST_HI_END:  state_n = ST_RD;
      ST_RD:      state_n = ST_RPAUSE;
      ST_RPAUSE:  state_n = ST_RD_OPEN;
      ST_RD_OPEN: begin
        state_n = ST_R_STB;
        cnt_n   = '0;
      end
      ST_R_STB: begin
        state_n = ST_R_GAP;
        cnt_n   = cnt_q + 1'b1;
      end
      ST_R_GAP:   state_n = (cnt_q == CNT_W'(N_STROBE)) ? ST_DONE : ST_R_STB;
      ST_DONE:    state_n = ST_IDLE;
      default:    state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tgt_q   <= '0;
      bank_q  <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      tgt_q   <= tgt_n;
      bank_q  <= bank_n;
    end
  end
endmodule

// File: rtl/fbaddr_out_reg.sv
module fbaddr_out_reg
  import fbaddr_preload_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int LO_LANE = 0,
  parameter int HI_LANE = 1,
  parameter int ADDR_W  = 16,
  parameter int BANK_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_t        state_n,
  input  logic [ADDR_W-1:0] tgt_n,
  input  logic [BANK_W-1:0] bank_n,
  output logic [3:0]        cmd_q,
  output logic              cke_q,
  output logic [LANES-1:0]  dqm_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [7:0]        bus_q,
  output logic              bus_oe_q,
  output logic              addr_oe_q,
  output logic              done_q
);
  localparam logic [LANES-1:0] ALL_MASK = '1;
  localparam logic [LANES-1:0] LO_OPEN  = ALL_MASK & ~(LANES'(1) << LO_LANE);
  localparam logic [LANES-1:0] HI_OPEN  = ALL_MASK & ~(LANES'(1) << HI_LANE);
  localparam logic [LANES-1:0] BOTH_OPEN = LO_OPEN & HI_OPEN;

  logic [3:0]       cmd_d;
  logic             cke_d, bus_oe_d, done_d;
  logic [LANES-1:0] dqm_d;
  logic [7:0]       bus_d;

  always_comb begin
    cmd_d    = CMD_NOP;
    cke_d    = 1'b0;
    dqm_d    = ALL_MASK;
    bus_d    = 8'h00;
    bus_oe_d = 1'b0;
    done_d   = 1'b0;
    unique case (state_n)
      ST_IDLE:    cke_d = 1'b1;
      ST_ACT:     begin cmd_d = CMD_ACT;   cke_d = 1'b1; end
      ST_WR:      begin cmd_d = CMD_WRITE; cke_d = 1'b1; end
      ST_LO_SET, ST_LO_STB: begin
        dqm_d    = LO_OPEN;
        bus_d    = tgt_n[7:0];
        bus_oe_d = 1'b1;
        cke_d    = (state_n == ST_LO_STB);
      end
      ST_HI_SET, ST_HI_STB: begin
        dqm_d    = HI_OPEN;
        bus_d    = tgt_n[15:8];
        bus_oe_d = 1'b1;
        cke_d    = (state_n == ST_HI_STB);
      end
      ST_RD:      begin cmd_d = CMD_READ; cke_d = 1'b1; end
      ST_RD_OPEN, ST_R_GAP: dqm_d = BOTH_OPEN;
      ST_R_STB:   begin dqm_d = BOTH_OPEN; cke_d = 1'b1; end
      ST_DONE:    begin dqm_d = BOTH_OPEN; done_d = 1'b1; end
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= CMD_NOP;
      cke_q     <= 1'b1;
      dqm_q     <= ALL_MASK;
      bank_q    <= '0;
      bus_q     <= 8'h00;
      bus_oe_q  <= 1'b0;
      addr_oe_q <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      cmd_q     <= cmd_d;
      cke_q     <= cke_d;
      dqm_q     <= dqm_d;
      bank_q    <= bank_n;
      bus_q     <= bus_d;
      bus_oe_q  <= bus_oe_d;
      addr_oe_q <= (state_n == ST_IDLE);
      done_q    <= done_d;
    end
  end
endmodule

// File: rtl/fbaddr_preload.sv
module fbaddr_preload
  import fbaddr_preload_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int LO_LANE  = 0,
  parameter int HI_LANE  = 1,
  parameter int BANK_W   = 2,
  parameter int N_STROBE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [15:0]       target_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic [LANES-1:0]  dqm_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [7:0]        bus_o,
  output logic              bus_oe_o,
  output logic              addr_oe_o,
  output logic              done_o
);
  localparam int ADDR_W = 16;

  seq_state_t        state_n;
  logic [ADDR_W-1:0] tgt_n;
  logic [BANK_W-1:0] bank_n;
  logic [3:0]        cmd_q;

  fbaddr_seq_fsm #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .N_STROBE(N_STROBE)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .target_i(target_i),
    .bank_i(bank_i), .state_n(state_n), .tgt_n(tgt_n), .bank_n(bank_n)
  );

  fbaddr_out_reg #(
    .LANES(LANES), .LO_LANE(LO_LANE), .HI_LANE(HI_LANE),
    .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_out (
    .clk(clk), .rst(rst), .state_n(state_n), .tgt_n(tgt_n), .bank_n(bank_n),
    .cmd_q(cmd_q), .cke_q(cke_o), .dqm_q(dqm_o), .bank_q(bank_o),
    .bus_q(bus_o), .bus_oe_q(bus_oe_o), .addr_oe_q(addr_oe_o), .done_q(done_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
endmodule

// File: rtl/fbaddr_preload_chk.sv
module fbaddr_preload_chk #(
  parameter int LANES  = 4,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic              cke_o,
  input logic [LANES-1:0]  dqm_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [7:0]        bus_o,
  input logic              bus_oe_o,
  input logic              addr_oe_o,
  input logic              done_o
);
  logic [3:0] cmd;
  assign cmd = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  p_act_masked_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0011) |-> (&dqm_o && !addr_oe_o));

  p_cmd_with_cke_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd != 4'b0111) |-> cke_o);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && addr_oe_o && cke_o && &dqm_o));

  p_bank_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !addr_oe_o |=> (addr_oe_o || $stable(bank_o)));

  p_one_lane_drive_r10: assert property (@(posedge clk) disable iff (rst)
    bus_oe_o |-> ($countones(~dqm_o) == 1 && !addr_oe_o));

  p_bus_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_o |-> (bus_o == 8'h00));

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
    (!addr_oe_o && $rose(cke_o)) |=> !cke_o);
endmodule

bind fbaddr_preload fbaddr_preload_chk #(.LANES(LANES), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
  .we_n_o(we_n_o), .cke_o(cke_o), .dqm_o(dqm_o), .bank_o(bank_o), .bus_o(bus_o),
  .bus_oe_o(bus_oe_o), .addr_oe_o(addr_oe_o), .done_o(done_o)
);

// File: tb/fbaddr_preload_tb.sv
module fbaddr_preload_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEQ_LEN    = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] target_i = '0;
  logic [1:0]  bank_i = '0;
  logic        cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o, bus_oe_o, addr_oe_o, done_o;
  logic [3:0]  dqm_o;
  logic [1:0]  bank_o;
  logic [7:0]  bus_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbaddr_preload u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .target_i(target_i), .bank_i(bank_i),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .cke_o(cke_o), .dqm_o(dqm_o), .bank_o(bank_o), .bus_o(bus_o),
    .bus_oe_o(bus_oe_o), .addr_oe_o(addr_oe_o), .done_o(done_o)
  );

  // row = {addr_oe, cmd[3:0], cke, dqm[3:0], bus_oe, bus[7:0], done, bank[1:0]}
  function automatic logic [21:0] observed();
    return {addr_oe_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o, dqm_o,
            bus_oe_o, bus_o, done_o, bank_o};
  endfunction

  function automatic logic [21:0] expected(int k, logic [15:0] t, logic [1:0] b);
    logic [3:0] c; logic ke; logic [3:0] m; logic oe; logic [7:0] d; logic dn; logic ao;
    c = 4'b0111; ke = 1'b0; m = 4'b1111; oe = 1'b0; d = 8'h00; dn = 1'b0; ao = 1'b0;
    case (k)
      0:  begin c = 4'b0011; ke = 1'b1; end
      1:  begin c = 4'b0100; ke = 1'b1; end
      3, 4: begin m = 4'b1110; oe = 1'b1; d = t[7:0]; ke = (k == 4); end
      6, 7: begin m = 4'b1101; oe = 1'b1; d = t[15:8]; ke = (k == 7); end
      9:  begin c = 4'b0101; ke = 1'b1; end
      11, 13, 15, 17: m = 4'b1100;
      12, 14, 16: begin m = 4'b1100; ke = 1'b1; end
      18: begin m = 4'b1100; dn = 1'b1; end
      19: begin ke = 1'b1; ao = 1'b1; end
      default: ;
    endcase
    return {ao, c, ke, m, oe, d, dn, b};
  endfunction

  function automatic string req_of(int k);
    case (k)
      0: return "R2";
      1, 2: return "R3";
      3, 4: return "R4";
      5, 6, 7, 8: return "R5";
      18, 19: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic check_row(string req, logic [21:0] exp_v);
    checks++;
    if (observed() !== exp_v) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, observed(), exp_v);
    end
  endtask

  // busy_at < 0: no extra start while busy
  task automatic run_seq(logic [15:0] t, logic [1:0] b, int busy_at, string tag);
    @(negedge clk);
    start_i = 1'b1; target_i = t; bank_i = b;
    @(negedge clk);
    start_i = 1'b0; target_i = ~t; bank_i = ~b;
    for (int k = 0; k <= SEQ_LEN; k++) begin
      if (k > 0) @(negedge clk);
      if (k == busy_at + 1) start_i = 1'b0;
      if (k == busy_at) begin start_i = 1'b1; target_i = t ^ 16'h5AA5; bank_i = ~b; end
      check_row((busy_at >= 0) ? "R8" : ((k == 0) ? "R9" : req_of(k)), expected(k, t, b));
    end
    start_i = 1'b0;
  endtask

  task automatic test_reset();
    check_row("R1", {1'b1, 4'b0111, 1'b1, 4'b1111, 1'b0, 8'h00, 1'b0, 2'b00});
  endtask

  task automatic test_idle_hold();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_row("R1", expected(19, 16'h0000, bank_o));
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();                          // R1
        run_seq(16'h1234, 2'd1, -1, "basic");  // R2..R7, R9, R10
        run_seq(16'hFF00, 2'd2, -1, "hi");
        run_seq(16'h00FF, 2'd3, -1, "lo");
        run_seq(16'hA55A, 2'd0, 5, "busy");    // R8 start during sequence
        test_idle_hold();                      // R1 bank held: R9
        run_seq(16'h8001, 2'd2, 12, "busy2");  // R8 during read strobes
      end
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule